// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator held as two 32-bit halves, a high half and a low half. A mode input picks between a long product (both operands taken as full 32-bit signed values) and a word product (only the low 16 bits of each operand, sign-extended). A saturation-enable input, sampled together with the start strobe, selects how the sum is clamped before it is written back. The two modes clamp in different ways.

The unit has two pipeline stages. The first registers the sign-extended product. The second adds it to the current accumulator, applies the saturation rule and writes both halves, raising a one-cycle done strobe in the same cycle. Back-to-back starts are supported. Each addition uses the accumulator value written by the operation before it. A clear input and two per-half load inputs let the surrounding logic set the accumulator directly, and these take priority over any result in flight.

Top module: `smac_unit`

## Requirements
- R1: After reset both accumulator halves read zero and `done_o` is low.
- R2: A start sampled at clock edge k makes the new halves visible after edge k+1, with `done_o` high for exactly that cycle. Starts on consecutive cycles each accumulate in order.
- R3: In long mode (`word_mode_i`=0) both operands are signed 32-bit values. Without saturation, the full signed 64-bit sum {high,low}+product is written back, with carries crossing between the halves.
- R4: In word mode (`word_mode_i`=1) only bits 15:0 of each operand are used, sign-extended from bit 15. Bits 31:16 of the operands have no effect.
- R5: In long mode with saturation, a negative 64-bit sum forces high-half bits 31:16 to ones. A non-negative sum clears high-half bits 31:15. All other bits come from the sum.
- R6: In word mode with saturation, a sum below -2^31 writes high=1 and low=0x80000000. A sum above 2^31-1 writes high=1 and low=0x7FFFFFFF.
- R7: In word mode with saturation, a sum within [-2^31, 2^31-1] is written unchanged as 64 bits.
- R8: `clr_i` zeroes both halves at the next edge. It overrides loads and any in-flight result.
- R9: `ld_hi_i` writes `ld_data_i` into the high half and `ld_lo_i` writes it into the low half. A half that is not loaded keeps its value.
- R10: If `clr_i`, `ld_hi_i` or `ld_lo_i` is active in the cycle a result would be written, that result is dropped and `done_o` stays low.
- R11: Mode and saturation enable are captured with the start strobe. Changing them afterwards does not alter the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one multiply-accumulate |
| word_mode_i | input | 1 | 1 = 16x16 word product, 0 = 32x32 long product |
| sat_en_i | input | 1 | Enable saturation of the written result |
| op_a_i | input | 32 | First multiplicand |
| op_b_i | input | 32 | Second multiplicand |
| clr_i | input | 1 | Zero both accumulator halves |
| ld_hi_i | input | 1 | Load high half from `ld_data_i` |
| ld_lo_i | input | 1 | Load low half from `ld_data_i` |
| ld_data_i | input | 32 | Direct load value |
| mach_o | output | 32 | Accumulator high half |
| macl_o | output | 32 | Accumulator low half |
| done_o | output | 1 | One-cycle strobe: updated halves visible |

## Verification
The assertions assume that every control input is a known 0 or 1 once reset is released. They also assume that `start_i` is low throughout reset, because the done check looks two cycles back. The bench drives all inputs on the falling edge and holds every strobe low during reset. It raises loads, clears and starts only in the cycles each test intends, so the override rules are exercised on purpose and never by stray overlap.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic {
        MODE_LONG = 1'b0,
        MODE_WORD = 1'b1
    } mac_mode_e;

endpackage

// File: rtl/smac_product.sv
module smac_product
    import smac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    input  mac_mode_e             mode_i,
    output logic [2*DATA_W-1:0]   prod_o
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_x;
    logic [DATA_W-1:0] b_x;
    logic signed [ACC_W-1:0] a_w;
    logic signed [ACC_W-1:0] b_w;

    // Pick operand width: word mode keeps the low half and sign-extends it.
    always_comb begin
        if (mode_i == MODE_WORD) begin
            a_x = {{(DATA_W-HALF_W){a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
            b_x = {{(DATA_W-HALF_W){b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};
        end else begin
            a_x = a_i;
            b_x = b_i;
        end
        a_w    = {{DATA_W{a_x[DATA_W-1]}}, a_x};
        b_w    = {{DATA_W{b_x[DATA_W-1]}}, b_x};
        prod_o = a_w * b_w;
    end

endmodule

// File: rtl/smac_sat.sv
module smac_sat
    import smac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic [2*DATA_W-1:0]   acc_i,
    input  logic [2*DATA_W-1:0]   prod_i,
    input  mac_mode_e             mode_i,
    input  logic                  sat_i,
    output logic [DATA_W-1:0]     hi_o,
    output logic [DATA_W-1:0]     lo_o
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [ACC_W-1:0]  LIM_LO  = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic [ACC_W-1:0]  LIM_HI  = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_SET = {{HALF_W{1'b1}}, {(DATA_W-HALF_W){1'b0}}};
    localparam logic [DATA_W-1:0] POS_KEEP = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MARK    = DATA_W'(1);
    localparam logic [DATA_W-1:0] MIN_LO  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_LO  = {1'b0, {(DATA_W-1){1'b1}}};

    logic [ACC_W-1:0] sum;
    logic             below;
    logic             above;

    always_comb begin
        sum   = acc_i + prod_i;
        below = $signed(sum) < $signed(LIM_LO);
        above = $signed(sum) > $signed(LIM_HI);
        hi_o  = sum[ACC_W-1:DATA_W];
        lo_o  = sum[DATA_W-1:0];
        if (sat_i) begin
            if (mode_i == MODE_LONG) begin
                if (sum[ACC_W-1]) hi_o = hi_o | NEG_SET;
                else              hi_o = hi_o & POS_KEEP;
            end else if (below) begin
                hi_o = MARK;
                lo_o = MIN_LO;
            end else if (above) begin
                hi_o = MARK;
                lo_o = MAX_LO;
            end
        end
    end

    // R5: long-mode saturation leaves the top bits as a sign fill
    assert_long_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sat_i && mode_i == MODE_LONG) |->
            ((hi_o[DATA_W-1:DATA_W-HALF_W] == '1) ||
             (hi_o[DATA_W-1:DATA_W-HALF_W-1] == '0)));

    // R6/R7: word-mode saturated high half is a plain sign extension or the marker
    assert_word_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sat_i && mode_i == MODE_WORD) |->
            (hi_o == '0 || hi_o == '1 || hi_o == MARK));

    // R6: the marker always comes with one of the two clamp values
    assert_word_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sat_i && mode_i == MODE_WORD && hi_o == MARK) |->
            (lo_o == MIN_LO || lo_o == MAX_LO));

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              word_mode_i,
    input  logic              sat_en_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              clr_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic [DATA_W-1:0] ld_data_i,
    output logic [DATA_W-1:0] mach_o,
    output logic [DATA_W-1:0] macl_o,
    output logic              done_o
);
    localparam int ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic              s1_vld;
        mac_mode_e         s1_mode;
        logic              s1_sat;
        logic [ACC_W-1:0]  s1_prod;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic              done;
    } mac_state_t;

    mac_state_t st_d, st_q;

    mac_mode_e         mode_in;
    logic [ACC_W-1:0]  prod_w;
    logic [DATA_W-1:0] sat_hi;
    logic [DATA_W-1:0] sat_lo;
    logic              wr_ok;

    assign mode_in = mac_mode_e'(word_mode_i);

    smac_product #(.DATA_W(DATA_W)) u_prod (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .mode_i (mode_in),
        .prod_o (prod_w)
    );

    smac_sat #(.DATA_W(DATA_W)) u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.s1_vld),
        .acc_i  ({st_q.hi, st_q.lo}),
        .prod_i (st_q.s1_prod),
        .mode_i (st_q.s1_mode),
        .sat_i  (st_q.s1_sat),
        .hi_o   (sat_hi),
        .lo_o   (sat_lo)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.s1_vld = start_i;
        if (start_i) begin
            st_d.s1_mode = mode_in;
            st_d.s1_sat  = sat_en_i;
            st_d.s1_prod = prod_w;
        end
        wr_ok = st_q.s1_vld && !clr_i && !ld_hi_i && !ld_lo_i;
        if (wr_ok) begin
            st_d.hi   = sat_hi;
            st_d.lo   = sat_lo;
            st_d.done = 1'b1;
        end
        if (ld_hi_i) st_d.hi = ld_data_i;
        if (ld_lo_i) st_d.lo = ld_data_i;
        if (clr_i) begin
            st_d.hi = '0;
            st_d.lo = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mach_o = st_q.hi;
    assign macl_o = st_q.lo;
    assign done_o = st_q.done;

    // R8: clear empties both halves one edge later
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mach_o == '0 && macl_o == '0));

    // R2: a done strobe only ever follows a start two edges earlier
    assert_done_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2));

    // R10: direct writes suppress the completion strobe
    assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || ld_hi_i || ld_lo_i) |=> !done_o);

    // R9: a high-half load without clear lands on the output
    assert_load_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi_i && !clr_i) |=> (mach_o == $past(ld_data_i)));

endmodule

// File: tb/smac_unit_tb.sv
module smac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, word_mode_i = 1'b0, sat_en_i = 1'b0;
    logic [31:0] op_a_i = '0, op_b_i = '0, ld_data_i = '0;
    logic        clr_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
    logic [31:0] mach_o, macl_o;
    logic        done_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    smac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_mode_i(word_mode_i),
        .sat_en_i(sat_en_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .clr_i(clr_i),
        .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i), .ld_data_i(ld_data_i),
        .mach_o(mach_o), .macl_o(macl_o), .done_o(done_o)
    );

    // pre_hi, pre_lo, a, b, word, sat, exp_hi, exp_lo
    typedef struct packed {
        logic [31:0] pre_hi, pre_lo, a, b;
        logic        word, sat;
        logic [31:0] exp_hi, exp_lo;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0, 32'h0, 32'd3, 32'd5, 1'b0, 1'b0, 32'h0, 32'd15},                          // R3
        '{32'h0, 32'h0, 32'hFFFFFFFE, 32'd7, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFF2},      // R3
        '{32'h0, 32'd10, 32'hFFFF0004, 32'h12340003, 1'b1, 1'b0, 32'h0, 32'd22},           // R4
        '{32'h0, 32'h0, 32'h00008000, 32'h00008000, 1'b1, 1'b0, 32'h0, 32'h40000000},      // R4
        '{32'h0, 32'h7FFFFFF0, 32'h100, 32'h1, 1'b1, 1'b1, 32'h1, 32'h7FFFFFFF},           // R6
        '{32'hFFFFFFFF, 32'h80000010, 32'hFFFF, 32'h20, 1'b1, 1'b1, 32'h1, 32'h80000000},  // R6
        '{32'hFFFFFFFF, 32'hFFFFFFF0, 32'd4, 32'd2, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFF8},// R7
        '{32'h80000000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF0000, 32'h0},             // R5
        '{32'h12345678, 32'h9ABCDEF0, 32'd1, 32'd1, 1'b0, 1'b1, 32'h00005678, 32'h9ABCDEF1},// R5
        '{32'h0, 32'h0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 32'h3FFFFFFF, 32'h00000001},// R3
        '{32'h1, 32'hFFFFFFFF, 32'd1, 32'd1, 1'b1, 1'b0, 32'h2, 32'h0}                     // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] hi, input logic [31:0] lo);
        ld_hi_i = 1'b1; ld_data_i = hi;
        @(negedge clk);
        ld_hi_i = 1'b0; ld_lo_i = 1'b1; ld_data_i = lo;
        @(negedge clk);
        ld_lo_i = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic w, input logic s);
        start_i = 1'b1; op_a_i = a; op_b_i = b; word_mode_i = w; sat_en_i = s;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 hi", mach_o, 32'h0);
        check("R1 lo", macl_o, 32'h0);
        check("R1 done", {31'h0, done_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            preload(VECS[i].pre_hi, VECS[i].pre_lo);
            issue(VECS[i].a, VECS[i].b, VECS[i].word, VECS[i].sat);
            check("R2 done low mid-pipe", {31'h0, done_o}, 32'h0);
            @(negedge clk);
            check("R2 done", {31'h0, done_o}, 32'h1);
            check($sformatf("R3-7 vec%0d hi", i), mach_o, VECS[i].exp_hi);
            check($sformatf("R3-7 vec%0d lo", i), macl_o, VECS[i].exp_lo);
            @(negedge clk);
            check("R2 done one cycle", {31'h0, done_o}, 32'h0);
        end

        // R2: back-to-back starts accumulate in order
        clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
        start_i = 1'b1; op_a_i = 32'd2; op_b_i = 32'd3; word_mode_i = 1'b0; sat_en_i = 1'b0;
        @(negedge clk);
        op_a_i = 32'd4; op_b_i = 32'd5;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 first of pair", macl_o, 32'd6);
        @(negedge clk);
        check("R2 second of pair", macl_o, 32'd26);
        check("R2 second done", {31'h0, done_o}, 32'h1);

        // R8: clear beats a simultaneous load
        clr_i = 1'b1; ld_hi_i = 1'b1; ld_data_i = 32'hDEADBEEF;
        @(negedge clk);
        clr_i = 1'b0; ld_hi_i = 1'b0;
        check("R8 hi", mach_o, 32'h0);
        check("R8 lo", macl_o, 32'h0);

        // R9: low-only load keeps high half
        preload(32'hA5A5A5A5, 32'h11111111);
        ld_lo_i = 1'b1; ld_data_i = 32'h22222222;
        @(negedge clk);
        ld_lo_i = 1'b0;
        check("R9 hi held", mach_o, 32'hA5A5A5A5);
        check("R9 lo loaded", macl_o, 32'h22222222);

        // R10: load in the write cycle drops the result
        issue(32'd100, 32'd100, 1'b0, 1'b0);
        ld_lo_i = 1'b1; ld_data_i = 32'h5;
        @(negedge clk);
        ld_lo_i = 1'b0;
        check("R10 done suppressed", {31'h0, done_o}, 32'h0);
        check("R10 hi unchanged", mach_o, 32'hA5A5A5A5);
        check("R10 lo is load", macl_o, 32'h5);

        // R8: clear drops an in-flight result
        issue(32'd7, 32'd7, 1'b0, 1'b0);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R8 in-flight hi", mach_o, 32'h0);
        check("R8 in-flight lo", macl_o, 32'h0);

        // R11: mode and saturation captured with start
        preload(32'h0, 32'h7FFFFFF0);
        issue(32'h100, 32'h1, 1'b1, 1'b1);
        word_mode_i = 1'b0; sat_en_i = 1'b0;
        @(negedge clk);
        check("R11 hi", mach_o, 32'h1);
        check("R11 lo", macl_o, 32'h7FFFFFFF);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule